// File: doc/BRIEF.md
# PWM-Locked Synchronization Pulse Generator

This block produces a periodic positive pulse whose rising edge is locked to the period centers of a companion PWM timer. The PWM timer supplies a one-cycle center strobe and its current period length T in clock ticks. One clock cycle of this block equals one timer tick. The pulse is issued once every N PWM periods, where N is a working prescaler value. Its rising edge is offset from the qualifying center by a signed tick count, and its width is a programmable number of ticks. An interrupt strobe accompanies every rising edge.

A negative offset places the edge before the *following* center. The delay is then computed as T plus the offset, using the T present at the qualifying center, so the edge follows period changes. The working prescaler is loaded in one of two modes. In synchronized mode it is loaded only at the PWM reload strobe, so a new pulse rate takes effect in the same instant as the new PWM values. In unsynchronized mode the host loads it directly with a write strobe.

A control state machine has four states: IDLE, DELAY, PULSE and HALT. Its transitions are:

- *launch* (IDLE→DELAY) on a qualifying center.
- *fire* (DELAY→PULSE) when the delay count is exhausted and the width is nonzero.
- *empty* (DELAY→IDLE) when the delay is exhausted and the width is zero.
- *expire* (PULSE→IDLE) when the width count is exhausted.
- *trip* (any→HALT) on an illegal offset.
- *recover* (HALT→IDLE) once the offset is legal.
- *abort* (any→IDLE) on an init request.

*trip* has priority over *abort*, and both have priority over the others.

Top module: `pwm_sync_pulse`

## Requirements
- R1: With working prescaler N (N=0 behaves as 1), a pulse is launched on one center strobe out of every N. A center qualifies when the period counter is zero; each center then reloads the counter with N-1 or decrements it.
- R2: With offset M ≥ 0, `pulse_out` goes high at the (M+1)th rising clock edge after the edge that samples `center_stb`.
- R3: `pulse_out` stays high for exactly `pulse_width` cycles. A width of 0 produces neither a pulse nor an interrupt.
- R4: With offset M < 0, the delay is T+M, where T is the `period` value present at the qualifying center. The edge therefore tracks changes of T.
- R5: `irq` is high for exactly one cycle, and that cycle is the first high cycle of `pulse_out`.
- R6: When 4·|M| ≥ T, `cfg_err` goes high from the next clock edge. While it is high, `pulse_out` and `irq` stay low and no pulse is launched. It clears one edge after the offset becomes legal again.
- R7: With `sync_mode`=1, the working prescaler takes `presc_host` only on `reload_stb`, and `presc_wr` is ignored. With `sync_mode`=0, it takes `presc_host` on `presc_wr`, and `reload_stb` is ignored.
- R8: `init_req` clears the period counter, so the next center strobe qualifies, and returns the state machine to IDLE.
- R9: After reset, `pulse_out`, `irq` and `cfg_err` are low, the working prescaler is 1, and the first center strobe qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| center_stb | input | 1 | One-cycle PWM period center strobe |
| period | input | 16 | Current PWM period T in ticks |
| reload_stb | input | 1 | One-cycle PWM reload instant |
| move_ofs | input | 16 | Signed edge offset from the center, in ticks |
| pulse_width | input | 16 | Pulse width in ticks |
| presc_host | input | 16 | Host prescaler value |
| presc_wr | input | 1 | Direct load of the working prescaler (unsynchronized mode) |
| sync_mode | input | 1 | 1: prescaler loaded at reload strobe |
| init_req | input | 1 | Restart the period count and abort any pending pulse |
| pulse_out | output | 1 | Synchronization pulse |
| irq | output | 1 | One-cycle interrupt on each rising edge |
| cfg_err | output | 1 | Offset violates the quarter-period rule |

## Verification
Center strobes are driven on a falling edge and sampled on the next rising edge. The rising edge of `pulse_out` is therefore due at the falling edge D+2 cycles after the strobe was driven, where D is M or T+M. The driver computes that cycle from a small prescaler-count model and pushes it, with the width and a requirement tag, into a queue. A monitor checks each rising edge against the queue on falling edges, checks `irq` in the same cycle and low in the next, and checks the width at the falling edge of the pulse. `cfg_err` is due one edge after an offset change and is sampled at the following falling edge. Suppressed pulses are checked by comparing the count of observed rises before and after a stimulus.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2,
        ST_HALT  = 2'd3
    } sp_state_e;
endpackage

// File: rtl/sp_presc_track.sv
module sp_presc_track #(
    parameter int PRESC_W = 16,
    parameter logic [PRESC_W-1:0] RST_PRESC = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_mode,
    input  logic               presc_wr,
    input  logic [PRESC_W-1:0] presc_host,
    input  logic               reload_stb,
    input  logic               center_stb,
    input  logic               init_req,
    output logic               launch_ok
);
    logic [PRESC_W-1:0] presc_work;
    logic [PRESC_W-1:0] pcnt;
    logic [PRESC_W-1:0] reload_val;
    logic               load_en;

    assign load_en    = sync_mode ? reload_stb : presc_wr;
    assign reload_val = (presc_work == '0) ? '0 : presc_work - 1'b1;
    assign launch_ok  = center_stb && !init_req && (pcnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       presc_work <= RST_PRESC;
        else if (load_en) presc_work <= presc_host;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pcnt <= '0;
        else if (init_req)   pcnt <= '0;
        else if (center_stb) pcnt <= (pcnt == '0) ? reload_val : pcnt - 1'b1;
    end

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !reload_stb) |=> $stable(presc_work)); // R7
    AST_INIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> (pcnt == '0)); // R8
endmodule

// File: rtl/sp_offset_calc.sv
module sp_offset_calc #(
    parameter int TW = 16
) (
    input  logic signed [TW-1:0] move_ofs,
    input  logic        [TW-1:0] period,
    output logic        [TW-1:0] delay,
    output logic                 cfg_bad
);
    localparam int MW = TW + 3;
    logic [TW:0]   abs_move;
    logic [MW-1:0] mag4;

    always_comb begin
        if (move_ofs[TW-1]) abs_move = (TW+1)'(-$signed({move_ofs[TW-1], move_ofs}));
        else                abs_move = {1'b0, move_ofs};
        mag4    = {abs_move, 2'b00};
        cfg_bad = mag4 >= {3'b000, period};
        delay   = move_ofs[TW-1] ? period + $unsigned(move_ofs) : $unsigned(move_ofs);
    end
endmodule

// File: rtl/sp_pulse_fsm.sv
module sp_pulse_fsm
    import sp_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic [TW-1:0] delay,
    input  logic [TW-1:0] pw,
    input  logic          cfg_bad,
    input  logic          init_req,
    output logic          pulse_out,
    output logic          irq,
    output logic          cfg_err
);
    sp_state_e     state, nxt;
    logic [TW-1:0] cnt, cnt_nxt;

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        if (cfg_bad) begin
            nxt = ST_HALT;                       // trip
        end else if (init_req) begin
            nxt = ST_IDLE;                       // abort
        end else begin
            unique case (state)
                ST_IDLE: if (launch) begin
                    nxt     = ST_DELAY;          // launch
                    cnt_nxt = delay;
                end
                ST_DELAY: begin
                    if (cnt == '0) begin
                        if (pw == '0) nxt = ST_IDLE;  // empty
                        else begin
                            nxt     = ST_PULSE;  // fire
                            cnt_nxt = pw - 1'b1;
                        end
                    end else cnt_nxt = cnt - 1'b1;
                end
                ST_PULSE: begin
                    if (cnt == '0) nxt = ST_IDLE; // expire
                    else cnt_nxt = cnt - 1'b1;
                end
                ST_HALT: nxt = ST_IDLE;          // recover
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (state == ST_DELAY) && (nxt == ST_PULSE);
    end

    assign pulse_out = (state == ST_PULSE);
    assign cfg_err   = (state == ST_HALT);

    AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pulse_out && !$past(pulse_out))); // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!pulse_out && !irq)); // R6
    AST_BAD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> cfg_err); // R6
    AST_INIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        init_req |=> !pulse_out); // R8
endmodule

// File: rtl/pwm_sync_pulse.sv
module pwm_sync_pulse #(
    parameter int TW      = 16,
    parameter int PRESC_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 center_stb,
    input  logic        [TW-1:0] period,
    input  logic                 reload_stb,
    input  logic signed [TW-1:0] move_ofs,
    input  logic        [TW-1:0] pulse_width,
    input  logic   [PRESC_W-1:0] presc_host,
    input  logic                 presc_wr,
    input  logic                 sync_mode,
    input  logic                 init_req,
    output logic                 pulse_out,
    output logic                 irq,
    output logic                 cfg_err
);
    logic          launch_ok;
    logic [TW-1:0] delay;
    logic          cfg_bad;

    sp_presc_track #(.PRESC_W(PRESC_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_mode  (sync_mode),
        .presc_wr   (presc_wr),
        .presc_host (presc_host),
        .reload_stb (reload_stb),
        .center_stb (center_stb),
        .init_req   (init_req),
        .launch_ok  (launch_ok)
    );

    sp_offset_calc #(.TW(TW)) u_ofs (
        .move_ofs (move_ofs),
        .period   (period),
        .delay    (delay),
        .cfg_bad  (cfg_bad)
    );

    sp_pulse_fsm #(.TW(TW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch_ok),
        .delay     (delay),
        .pw        (pulse_width),
        .cfg_bad   (cfg_bad),
        .init_req  (init_req),
        .pulse_out (pulse_out),
        .irq       (irq),
        .cfg_err   (cfg_err)
    );
endmodule

// File: tb/test_pwm_sync_pulse.sv
module test_pwm_sync_pulse;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               center_stb = 1'b0;
    logic        [15:0] period = 16'd200;
    logic               reload_stb = 1'b0;
    logic signed [15:0] move_ofs = 16'sd0;
    logic        [15:0] pulse_width = 16'd5;
    logic        [15:0] presc_host = 16'd1;
    logic               presc_wr = 1'b0;
    logic               sync_mode = 1'b0;
    logic               init_req = 1'b0;
    logic               pulse_out, irq, cfg_err;

    always #4 clk = ~clk;

    pwm_sync_pulse i_pwm_sync_pulse (
        .clk(clk), .rst_n(rst_n), .center_stb(center_stb), .period(period),
        .reload_stb(reload_stb), .move_ofs(move_ofs), .pulse_width(pulse_width),
        .presc_host(presc_host), .presc_wr(presc_wr), .sync_mode(sync_mode),
        .init_req(init_req), .pulse_out(pulse_out), .irq(irq), .cfg_err(cfg_err)
    );

    typedef struct { int rise; int width; string tag; } exp_t;
    exp_t sbq[$];
    exp_t e;
    int cyc = 0, n_chk = 0, n_err = 0, rises = 0, irqs = 0;
    int m_presc = 1, m_pcnt = 0;
    bit prev = 1'b0, just_rose = 1'b0;
    int wcnt = 0, exp_w = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_bad();
        int mv = int'(move_ofs);
        int a = (mv < 0) ? -mv : mv;
        return (a * 4) >= int'(period);
    endfunction

    function automatic int model_delay();
        int mv = int'(move_ofs);
        return (mv < 0) ? int'(period) + mv : mv;
    endfunction

    // driver: one center strobe, expectation pushed into the scoreboard
    task automatic center_once(input string tag);
        exp_t x;
        @(negedge clk);
        if (m_pcnt == 0) begin
            if (!model_bad() && pulse_width != 0) begin
                x.rise = cyc + model_delay() + 2;
                x.width = int'(pulse_width);
                x.tag = tag;
                sbq.push_back(x);
            end
            m_pcnt = (m_presc == 0) ? 0 : m_presc - 1;
        end else m_pcnt--;
        center_stb = 1'b1;
        @(negedge clk) center_stb = 1'b0;
        repeat (int'(period) - 2) @(negedge clk);
    endtask

    task automatic centers(input int n, input string tag);
        for (int i = 0; i < n; i++) center_once(tag);
    endtask

    task automatic do_init();
        @(negedge clk) init_req = 1'b1;
        @(negedge clk) init_req = 1'b0;
        m_pcnt = 0;
    endtask

    task automatic host_write(input int v);
        presc_host = 16'(v);
        @(negedge clk) presc_wr = 1'b1;
        @(negedge clk) presc_wr = 1'b0;
        if (!sync_mode) m_presc = v;
    endtask

    task automatic pwm_reload(input int v);
        presc_host = 16'(v);
        @(negedge clk) reload_stb = 1'b1;
        @(negedge clk) reload_stb = 1'b0;
        if (sync_mode) m_presc = v;
    endtask

    // monitor: pops expectations as pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq) irqs++;
            if (just_rose) begin
                chk(irq == 1'b0, "R5 irq lasts one cycle", irq, 0);
                just_rose = 1'b0;
            end
            if (pulse_out && !prev) begin
                rises++;
                just_rose = 1'b1;
                wcnt = 1;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R1 unexpected pulse", cyc, -1);
                    exp_w = 0;
                end else begin
                    e = sbq.pop_front();
                    chk(cyc == e.rise, {e.tag, " rise time"}, cyc, e.rise);
                    chk(irq == 1'b1, "R5 irq with rise", irq, 1);
                    exp_w = e.width;
                end
            end else if (pulse_out) begin
                wcnt++;
            end else if (prev) begin
                chk(wcnt == exp_w, "R3 pulse width", wcnt, exp_w);
            end
            prev = pulse_out;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int r0, q0;
        repeat (4) @(negedge clk);
        chk(pulse_out == 1'b0, "R9 reset pulse_out", pulse_out, 0);
        chk(irq == 1'b0, "R9 reset irq", irq, 0);
        chk(cfg_err == 1'b0, "R9 reset cfg_err", cfg_err, 0);
        rst_n = 1'b1;

        // R9 / R2: default prescaler 1, positive offset
        move_ofs = 16'sd10;
        centers(3, "R2");
        move_ofs = 16'sd0;
        centers(1, "R2");
        // R4: negative offset, then period change
        move_ofs = -16'sd20;
        centers(2, "R4");
        period = 16'd160;
        centers(2, "R4");
        period = 16'd200;
        // R1: prescaler 3 in unsynchronized mode
        move_ofs = 16'sd5;
        host_write(3);
        do_init();
        centers(7, "R1");
        // R7: synchronized mode
        sync_mode = 1'b1;
        host_write(2);
        centers(4, "R7");
        pwm_reload(2);
        centers(4, "R7");
        sync_mode = 1'b0;
        pwm_reload(1);
        centers(2, "R7");
        // R8: init restarts the count
        host_write(4);
        do_init();
        centers(2, "R8");
        do_init();
        centers(1, "R8");
        // R3: zero and short widths
        host_write(1);
        do_init();
        pulse_width = 16'd0;
        r0 = rises;
        q0 = irqs;
        centers(2, "R3");
        chk(rises == r0, "R3 zero width gives no pulse", rises - r0, 0);
        chk(irqs == q0, "R3 zero width gives no irq", irqs - q0, 0);
        pulse_width = 16'd1;
        centers(2, "R3");
        pulse_width = 16'd7;
        centers(1, "R3");
        // R6: quarter-period rule
        move_ofs = 16'sd49;
        centers(1, "R6");
        @(negedge clk) move_ofs = 16'sd50;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R6 error at limit", cfg_err, 1);
        r0 = rises;
        centers(3, "R6");
        chk(rises == r0, "R6 no pulse while in error", rises - r0, 0);
        @(negedge clk) move_ofs = -16'sd50;
        @(negedge clk);
        chk(cfg_err == 1'b1, "R6 error negative limit", cfg_err, 1);
        @(negedge clk) move_ofs = -16'sd49;
        @(negedge clk);
        chk(cfg_err == 1'b0, "R6 error cleared", cfg_err, 0);
        do_init();
        centers(1, "R6");

        repeat (300) @(negedge clk);
        chk(sbq.size() == 0, "R1 expected pulses missing", sbq.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule